// File: doc/BRIEF.md
# Ping-Pong DMA Channel Engine

This block runs a single DMA channel. It holds two descriptor sets, primary and alternate. Each set has a source end pointer, a destination end pointer and a packed 32-bit control word. A peripheral asks for service with a single request or a burst request. The engine then copies byte items through one memory port: a read at the source address, then a write of the same byte to the destination address. Addresses are computed backwards from inclusive end pointers and the count that remains, so the last item lands exactly on each end pointer.

Work is split into arbitration groups of 2^N items. After each group the engine writes the remaining count back into the active control word and returns to idle, where it samples requests again. When a descriptor runs out, its mode field is cleared, a done pulse marks the half that finished, and in ping-pong mode the channel switches to the other descriptor. Software refills the idle half while the active half runs. If the half it switches to is stopped, the channel serves no further requests until software writes that half.

The memory port uses valid/ready. `mem_valid` is raised with a stable address, direction and write data. A beat completes on the rising edge where both `mem_valid` and `mem_ready` are high. While `mem_ready` is low the engine holds every port field, so the memory side may apply back-pressure for any number of cycles. Read data is taken from `mem_rdata` in the cycle the read beat completes.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Reset clears both control words and makes the primary set active. While `cfg_we` is high, the set chosen by `cfg_alt` (0 = primary, 1 = alternate) loads `cfg_src_end`, `cfg_dst_end` and `cfg_ctl`, and the new control word shows on `ctl_pri` or `ctl_alt` from the next cycle.
- R2: Each item is one read beat (`mem_write`=0) at the source address, followed by one write beat (`mem_write`=1) at the destination address that carries the byte just read. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` hold.
- R3: Increment codes sit at [31:30] (destination) and [27:26] (source). For code k in 0..2, an item's address is end pointer − ((remaining − 1) << k), so items ascend and the last one is at the end pointer. Code 3 uses the end pointer for every item.
- R4: The transfer-size field [13:4] holds the item count minus one, so a value of n moves n+1 items in total.
- R5: A burst request (`req_burst`) moves min(2^N, remaining) items, where N is the arbitration field [17:14] (N ≥ 10 counts as 1024). The engine then goes idle and samples requests again. A burst wins over a single request.
- R6: A single request (`req_single`) moves exactly one item.
- R7: While `burst_only` is high, `req_single` starts nothing: no beat is issued and the control words stay unchanged.
- R8: After each group, field [13:4] of the active control word becomes remaining − 1 and every other bit is kept. When the count runs out, mode [2:0] and field [13:4] are cleared instead, and `done_pri` or `done_alt` pulses for one cycle, never both together.
- R9: Requests are served only while the active set's mode [2:0] is non-zero. When mode 3 (ping-pong) runs out, the other set becomes active. Any other non-zero mode keeps the same set active once it runs out.
- R10: A configuration write to the inactive set in the same cycle as the active set's final write-back is kept, and the channel continues with that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor load strobe |
| cfg_alt | input | 1 | Target set: 0 primary, 1 alternate |
| cfg_src_end | input | AW | Inclusive source end pointer |
| cfg_dst_end | input | AW | Inclusive destination end pointer |
| cfg_ctl | input | 32 | Control word |
| burst_only | input | 1 | Ignore single requests |
| req_single | input | 1 | Single-item request level |
| req_burst | input | 1 | Burst request level |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken on read handshake |
| done_pri | output | 1 | Primary half finished (one cycle) |
| done_alt | output | 1 | Alternate half finished (one cycle) |
| ctl_pri | output | 32 | Current primary control word |
| ctl_alt | output | 32 | Current alternate control word |

## Verification
The delicate cycle is the final write-back of one half, which clears its mode and flips the active set. Software may reload the other half in that same cycle. The bench keeps a burst request asserted and leaves the alternate half stopped. At the falling edge where `done_pri` is seen, it drives a ping-pong load of the alternate set. It then judges the result at the ports: the alternate items must follow at their own addresses, the primary word must read stopped, and after the alternate half finishes the channel must go silent with the request still held.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int CTL_W  = 32;
  localparam int CNT_W  = 10;   // transfer-size field width
  localparam int DATA_W = 8;

  localparam logic [2:0] MODE_STOP     = 3'd0;
  localparam logic [2:0] MODE_PINGPONG = 3'd3;
  localparam logic [1:0] INC_FIXED     = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WB
  } dma_state_t;
endpackage

// File: rtl/dma_desc_bank.sv
module dma_desc_bank
  import dma_pp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_alt,
  input  logic [AW-1:0]               cfg_src_end,
  input  logic [AW-1:0]               cfg_dst_end,
  input  logic [CTL_W-1:0]            cfg_ctl,
  input  logic                        wb_en,
  input  logic                        wb_alt,
  input  logic [CTL_W-1:0]            wb_ctl,
  output logic [1:0][AW-1:0]          src_end,
  output logic [1:0][AW-1:0]          dst_end,
  output logic [1:0][CTL_W-1:0]       ctl
);
  // Set 0 is primary, set 1 alternate. Write-back wins over a load of the same set.
  for (genvar s = 0; s < 2; s++) begin : g_set
    logic hit_cfg, hit_wb;
    assign hit_cfg = cfg_we && (cfg_alt == s[0]);
    assign hit_wb  = wb_en && (wb_alt == s[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_end[s] <= '0;
        dst_end[s] <= '0;
        ctl[s]     <= '0;
      end else begin
        if (hit_cfg) begin
          src_end[s] <= cfg_src_end;
          dst_end[s] <= cfg_dst_end;
        end
        if (hit_wb)       ctl[s] <= wb_ctl;
        else if (hit_cfg) ctl[s] <= cfg_ctl;
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]  end_ptr,
  input  logic [1:0]     inc,
  input  logic [CNT_W:0] remaining,
  output logic [AW-1:0]  addr
);
  logic [CNT_W:0] back_items;
  logic [AW-1:0]  back_bytes;

  always_comb begin
    back_items = remaining - 1'b1;
    back_bytes = AW'(back_items) << inc;
    addr = (inc == INC_FIXED) ? end_ptr : end_ptr - back_bytes;
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] act_ctl,
  input  logic             req_single,
  input  logic             req_burst,
  input  logic             burst_only,
  input  logic             mem_ready,
  output logic             act_alt,
  output logic [CNT_W:0]   remaining,
  output logic             rd_phase,
  output logic             wr_phase,
  output logic             wb_en,
  output logic [CTL_W-1:0] wb_ctl,
  output logic             done_pri,
  output logic             done_alt
);
  dma_state_t     state;
  logic [CNT_W:0] grp;
  logic [CNT_W:0] rem_load, grp_cap, grp_load;
  logic [CNT_W-1:0] rem_m1;
  logic [2:0]     mode;
  logic [3:0]     arb;
  logic           start, finished;

  assign mode     = act_ctl[2:0];
  assign arb      = act_ctl[17:14];
  assign start    = (state == ST_IDLE) && (mode != MODE_STOP) &&
                    (req_burst || (req_single && !burst_only));
  assign rem_load = {1'b0, act_ctl[13:4]} + 1'b1;
  assign finished = (state == ST_WB) && (remaining == '0);
  assign rem_m1   = remaining[CNT_W-1:0] - 1'b1;

  always_comb begin
    if (arb >= 4'(CNT_W)) grp_cap = {1'b1, {CNT_W{1'b0}}};
    else                  grp_cap = (CNT_W+1)'(1) << arb;
    if (!req_burst)             grp_load = (CNT_W+1)'(1);
    else if (grp_cap < rem_load) grp_load = grp_cap;
    else                        grp_load = rem_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      grp       <= '0;
      act_alt   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          remaining <= rem_load;
          grp       <= grp_load;
          state     <= ST_RD;
        end
        ST_RD: if (mem_ready) state <= ST_WR;
        ST_WR: if (mem_ready) begin
          remaining <= remaining - 1'b1;
          grp       <= grp - 1'b1;
          state     <= (remaining == 1 || grp == 1) ? ST_WB : ST_RD;
        end
        ST_WB: begin
          state <= ST_IDLE;
          if (remaining == '0 && mode == MODE_PINGPONG) act_alt <= ~act_alt;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_phase = (state == ST_RD);
  assign wr_phase = (state == ST_WR);
  assign wb_en    = (state == ST_WB);
  assign done_pri = finished && !act_alt;
  assign done_alt = finished && act_alt;

  always_comb begin
    if (remaining == '0)
      wb_ctl = {act_ctl[31:14], {CNT_W{1'b0}}, act_ctl[3], MODE_STOP};
    else
      wb_ctl = {act_ctl[31:14], rem_m1, act_ctl[3:0]};
  end

  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req_burst) |=> (grp == 1)); // R6
  AST_BURST_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && burst_only && !req_burst) |=> (state == ST_IDLE)); // R7
  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase || wr_phase) |-> (grp != 0 && grp <= remaining)); // R5
  AST_PINGPONG_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && mode == MODE_PINGPONG) |=> (act_alt != $past(act_alt))); // R9
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import dma_pp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_alt,
  input  logic [AW-1:0]     cfg_src_end,
  input  logic [AW-1:0]     cfg_dst_end,
  input  logic [CTL_W-1:0]  cfg_ctl,
  input  logic              burst_only,
  input  logic              req_single,
  input  logic              req_burst,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_pri,
  output logic              done_alt,
  output logic [CTL_W-1:0]  ctl_pri,
  output logic [CTL_W-1:0]  ctl_alt
);
  logic [1:0][AW-1:0]    src_end, dst_end;
  logic [1:0][CTL_W-1:0] ctl;
  logic [CTL_W-1:0]      act_ctl, wb_ctl;
  logic                  act_alt, wb_en, rd_phase, wr_phase;
  logic [CNT_W:0]        remaining;
  logic [AW-1:0]         src_addr, dst_addr;
  logic [DATA_W-1:0]     data_q;

  dma_desc_bank #(.AW(AW)) u_bank (
    .clk, .rst_n, .cfg_we, .cfg_alt, .cfg_src_end, .cfg_dst_end, .cfg_ctl,
    .wb_en, .wb_alt(act_alt), .wb_ctl, .src_end, .dst_end, .ctl
  );

  assign act_ctl = ctl[act_alt];

  dma_seq u_seq (
    .clk, .rst_n, .act_ctl, .req_single, .req_burst, .burst_only, .mem_ready,
    .act_alt, .remaining, .rd_phase, .wr_phase, .wb_en, .wb_ctl,
    .done_pri, .done_alt
  );

  dma_addr_gen #(.AW(AW)) u_src_addr (
    .end_ptr(src_end[act_alt]), .inc(act_ctl[27:26]), .remaining, .addr(src_addr)
  );
  dma_addr_gen #(.AW(AW)) u_dst_addr (
    .end_ptr(dst_end[act_alt]), .inc(act_ctl[31:30]), .remaining, .addr(dst_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     data_q <= '0;
    else if (rd_phase && mem_ready) data_q <= mem_rdata;
  end

  assign mem_valid = rd_phase || wr_phase;
  assign mem_write = wr_phase;
  assign mem_addr  = wr_phase ? dst_addr : src_addr;
  assign mem_wdata = data_q;
  assign ctl_pri   = ctl[0];
  assign ctl_alt   = ctl[1];

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R2
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pri && done_alt)); // R8
  AST_PRI_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    done_pri |=> (ctl_pri[2:0] == MODE_STOP)); // R8
  AST_ALT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    done_alt |=> (ctl_alt[2:0] == MODE_STOP)); // R8
endmodule

// File: tb/tb_pingpong_dma_chan.sv
module tb_pingpong_dma_chan;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_alt = 1'b0;
  logic [AW-1:0] cfg_src_end = '0, cfg_dst_end = '0;
  logic [31:0] cfg_ctl = '0;
  logic burst_only = 1'b0, req_single = 1'b0, req_burst = 1'b0;
  logic mem_valid, mem_write, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic done_pri, done_alt;
  logic [31:0] ctl_pri, ctl_alt;

  int total = 0, bad = 0;
  int nwr = 0, ndone_pri = 0, ndone_alt = 0, cyc = 0;
  logic [AW-1:0] wr_addr [256];
  logic [7:0]    wr_data [256];

  always #10 clk = ~clk;  // 50 MHz

  pingpong_dma_chan #(.AW(AW)) dut (.*);

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = pat(mem_addr);

  function automatic logic [31:0] mkctl(input logic [1:0] dinc, input logic [1:0] sinc,
                                        input logic [3:0] arb, input logic [9:0] xfer,
                                        input logic [2:0] mode);
    return {dinc, 2'b00, sinc, 2'b00, 6'b0, arb, xfer, 1'b0, mode};
  endfunction

  // memory model and monitor: decide ready, then log the beat that completes at the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      nwr = 0; ndone_pri = 0; ndone_alt = 0;
    end else begin
      cyc++;
      mem_ready = (cyc % 3) != 0;
      if (mem_valid && mem_ready && mem_write && nwr < 256) begin
        wr_addr[nwr] = mem_addr;
        wr_data[nwr] = mem_wdata;
        nwr++;
      end
      if (done_pri) ndone_pri++;
      if (done_alt) ndone_alt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_single = 0; req_burst = 0; burst_only = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic alt, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [31:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_alt = alt; cfg_src_end = s; cfg_dst_end = d; cfg_ctl = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input bit burst);
    @(negedge clk);
    if (burst) req_burst = 1; else req_single = 1;
    @(negedge clk);
    req_burst = 0; req_single = 0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ctl_pri == 0, "R1 reset ctl_pri", ctl_pri, 0);
    chk(ctl_alt == 0, "R1 reset ctl_alt", ctl_alt, 0);
    chk(!mem_valid && !done_pri && !done_alt, "R1 reset outputs idle", {30'b0, mem_valid, done_pri}, 0);
    load(1, 16'h1111, 16'h2222, mkctl(2, 1, 5, 10'h155, 3'd3));
    chk(ctl_alt == mkctl(2, 1, 5, 10'h155, 3'd3), "R1 load alt", ctl_alt, mkctl(2, 1, 5, 10'h155, 3'd3));
    chk(ctl_pri == 0, "R1 primary untouched", ctl_pri, 0);
  endtask

  task automatic t_singles();
    do_reset();
    load(0, 16'h1000, 16'h2007, mkctl(0, 3, 3, 7, 3'd1));
    load(1, 16'h0500, 16'h0600, mkctl(0, 0, 3, 3, 3'd3));
    for (int k = 1; k <= 3; k++) begin
      pulse(0);
      chk(nwr == k, "R6 single moves one item", nwr, k);
      chk(wr_addr[k-1] == 16'h2000 + AW'(k-1), "R3 single dst addr", wr_addr[k-1], 16'h2000 + k - 1);
      chk(wr_data[k-1] == pat(16'h1000), "R2 R3 fixed source data", wr_data[k-1], pat(16'h1000));
    end
    chk(ctl_pri == mkctl(0, 3, 3, 4, 3'd1), "R8 write-back after singles", ctl_pri, mkctl(0, 3, 3, 4, 3'd1));
    burst_only = 1;
    pulse(0);
    chk(nwr == 3, "R7 single ignored under burst_only", nwr, 3);
    chk(ctl_pri == mkctl(0, 3, 3, 4, 3'd1), "R7 ctl unchanged", ctl_pri, mkctl(0, 3, 3, 4, 3'd1));
    pulse(1);
    chk(nwr == 8, "R5 burst capped by remaining", nwr, 8);
    chk(wr_addr[7] == 16'h2007, "R3 last item at end pointer", wr_addr[7], 16'h2007);
    chk(ndone_pri == 1 && ndone_alt == 0, "R8 done_pri pulse", {ndone_pri[15:0], ndone_alt[15:0]}, 32'h0001_0000);
    chk(ctl_pri == mkctl(0, 3, 3, 0, 3'd0), "R8 mode cleared", ctl_pri, mkctl(0, 3, 3, 0, 3'd0));
    pulse(1);
    chk(nwr == 8, "R9 basic mode does not swap", nwr, 8);
  endtask

  task automatic t_bursts();
    do_reset();
    load(0, 16'h0140, 16'h3013, mkctl(0, 0, 3, 19, 3'd1));
    pulse(1);
    chk(nwr == 8, "R5 first burst group", nwr, 8);
    chk(ctl_pri == mkctl(0, 0, 3, 11, 3'd1), "R8 group write-back", ctl_pri, mkctl(0, 0, 3, 11, 3'd1));
    pulse(1);
    chk(nwr == 16, "R5 second burst group", nwr, 16);
    pulse(1);
    chk(nwr == 20, "R4 total items n+1", nwr, 20);
    chk(ndone_pri == 1, "R8 one done", ndone_pri, 1);
    for (int i = 0; i < 20; i++) begin
      chk(wr_addr[i] == 16'h3000 + AW'(i), "R3 ascending dst", wr_addr[i], 16'h3000 + i);
      chk(wr_data[i] == pat(16'h012D + AW'(i)), "R2 data copied", wr_data[i], pat(16'h012D + AW'(i)));
    end
  endtask

  task automatic t_strides();
    do_reset();
    load(0, 16'h0086, 16'h4010, mkctl(2, 1, 2, 3, 3'd1));
    pulse(1);
    chk(nwr == 4, "R5 burst of four", nwr, 4);
    for (int i = 0; i < 4; i++) begin
      chk(wr_addr[i] == 16'h4004 + AW'(4*i), "R3 dst stride 4", wr_addr[i], 16'h4004 + 4*i);
      chk(wr_data[i] == pat(16'h0080 + AW'(2*i)), "R3 src stride 2", wr_data[i], pat(16'h0080 + AW'(2*i)));
    end
  endtask

  task automatic t_pingpong_race();
    do_reset();
    load(0, 16'h0210, 16'h5003, mkctl(0, 0, 2, 3, 3'd3));
    @(negedge clk);
    req_burst = 1;
    for (int w = 0; w < 200 && !done_pri; w++) @(negedge clk);
    chk(done_pri == 1, "R8 done_pri seen", done_pri, 1);
    cfg_we = 1; cfg_alt = 1; cfg_src_end = 16'h0302; cfg_dst_end = 16'h6002;
    cfg_ctl = mkctl(0, 0, 3, 2, 3'd3);
    @(negedge clk);
    cfg_we = 0;
    repeat (150) @(negedge clk);
    req_burst = 0;
    chk(nwr == 7, "R10 R9 alternate ran then halted", nwr, 7);
    chk(ndone_pri == 1 && ndone_alt == 1, "R9 one done per half", {ndone_pri[15:0], ndone_alt[15:0]}, 32'h0001_0001);
    for (int i = 0; i < 3; i++) begin
      chk(wr_addr[4+i] == 16'h6000 + AW'(i), "R10 alternate dst", wr_addr[4+i], 16'h6000 + i);
      chk(wr_data[4+i] == pat(16'h0300 + AW'(i)), "R10 alternate data", wr_data[4+i], pat(16'h0300 + AW'(i)));
    end
    chk(ctl_pri[2:0] == 0, "R8 primary stopped", ctl_pri, 0);
    chk(ctl_alt == mkctl(0, 0, 3, 0, 3'd0), "R8 alternate stopped", ctl_alt, mkctl(0, 0, 3, 0, 3'd0));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_singles();
    t_bursts();
    t_strides();
    t_pingpong_race();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end
endmodule